// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block runs single machine cycles on a processor bus whose low address byte and data byte share one set of pins. A requester asks for an opcode fetch, a memory read or write, or an I/O read or write, and supplies a 16-bit address and the write data. The sequencer places the low address byte on the shared bus with an address strobe. It then drives an active-low read or write strobe, stretches the data phase while the target holds its ready line low, captures read data and reports completion with a one-clock done pulse.

Another bus master can ask for the bus with a hold request. The request is granted only between machine cycles. While the grant is active every bus output enable is released. After the request is withdrawn the grant acknowledge drops, and the bus is driven again one clock later. A halt input parks the sequencer in a halted state with the bus released. Three-state pins are modelled as separate output-enable signals.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset hlda_o is 0, ale_o is 0, rd_no and wr_no are 1, done_o is 0, addr_oe_o is 1, and with hold_i and halt_i low req_ready_o is 1.
- R2: Kind codes on req_kind_i are 0 fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write. From the first clock of a cycle to its end, {s1_o,s0_o} is 2'b11 for fetch, 2'b10 for either read and 2'b01 for either write, and io_m_o is 1 for I/O kinds and 0 otherwise.
- R3: In the first clock after acceptance ale_o is 1, ad_o holds address bits 7:0, addr_hi_o holds bits 15:8, ad_oe_o is 1, and neither rd_no nor wr_no is low.
- R4: In the second and third clocks a read kind drives rd_no low with ad_oe_o 0, and a write kind drives wr_no low with ad_o equal to the write data and ad_oe_o 1; rd_no and wr_no are never low together.
- R5: Each clock edge that ends the third clock with ready_i low adds one wait clock, during which the strobe stays low.
- R6: On the edge that ends the data phase with ready_i high, a read kind loads ad_i into rdata_o, which then holds until the next read; done_o is 1 for exactly the following clock.
- R7: A fetch lasts four clocks (one idle clock follows the data phase); every other kind lasts three clocks plus waits.
- R8: req_ready_o is 1 only in idle with hold_i and halt_i low; a request while it is 0 is ignored and starts no cycle.
- R9: hold_i is acted on only in idle: hold_i high at an idle edge makes hlda_o 1 from the next clock; hold_i raised during a cycle leaves hlda_o 0 until the cycle has finished.
- R10: While hlda_o is 1, and while halted, addr_oe_o, ad_oe_o and ctl_oe_o are 0.
- R11: hold_i low at an edge while hlda_o is 1 drops hlda_o for the next clock with all enables still 0; the clock after that the bus is driven again.
- R12: halt_i high at an idle edge enters the halted state, where {s1_o,s0_o} is 2'b00; halt_i low at an edge returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Cycle request |
| req_kind_i | input | 3 | Cycle kind code |
| req_addr_i | input | 16 | Cycle address |
| req_wdata_i | input | 8 | Write data |
| req_ready_o | output | 1 | Request can be accepted this clock |
| rdata_o | output | 8 | Captured read data |
| done_o | output | 1 | One-clock completion pulse |
| ready_i | input | 1 | Target ready, low inserts waits |
| hold_i | input | 1 | External bus request |
| hlda_o | output | 1 | Bus request granted |
| halt_i | input | 1 | Enter halted state |
| ale_o | output | 1 | Address latch strobe |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| io_m_o | output | 1 | 1 for I/O, 0 for memory |
| s1_o | output | 1 | Cycle status bit 1 |
| s0_o | output | 1 | Cycle status bit 0 |
| addr_hi_o | output | 8 | Address bits 15:8 |
| ad_o | output | 8 | Shared address/data bus out |
| ad_i | input | 8 | Shared bus in (read data) |
| addr_oe_o | output | 1 | Enable for addr_hi_o |
| ad_oe_o | output | 1 | Enable for ad_o |
| ctl_oe_o | output | 1 | Enable for rd_no, wr_no, io_m_o |

## Verification
The properties assume req_kind_i carries only the five defined codes and that hold_i and halt_i are levels a requester keeps stable across clocks rather than pulses. The stimulus draws kinds from 0 to 4, changes every input only at the falling clock edge, and raises hold and halt only between cycles except in one directed case that raises hold mid-cycle to check that the grant waits for the cycle boundary. Wait counts of zero to three exercise the stretched data phase for every kind.

// File: rtl/bus_seq_pkg.sv
`timescale 1ns/1ps
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_T3, ST_T4, ST_HALT, ST_HOLD, ST_HREL
  } seq_state_e;

  localparam int KIND_W = 3;
  localparam logic [KIND_W-1:0] KIND_FETCH = 3'd0;
  localparam logic [KIND_W-1:0] KIND_MRD   = 3'd1;
  localparam logic [KIND_W-1:0] KIND_MWR   = 3'd2;
  localparam logic [KIND_W-1:0] KIND_IORD  = 3'd3;
  localparam logic [KIND_W-1:0] KIND_IOWR  = 3'd4;

  localparam logic [1:0] STS_HALT  = 2'b00;
  localparam logic [1:0] STS_WRITE = 2'b01;
  localparam logic [1:0] STS_READ  = 2'b10;
  localparam logic [1:0] STS_FETCH = 2'b11;

  function automatic logic kind_is_write(logic [KIND_W-1:0] k);
    return (k == KIND_MWR) || (k == KIND_IOWR);
  endfunction

  function automatic logic kind_is_io(logic [KIND_W-1:0] k);
    return (k == KIND_IORD) || (k == KIND_IOWR);
  endfunction

  function automatic logic [1:0] kind_status(logic [KIND_W-1:0] k);
    if (k == KIND_FETCH) return STS_FETCH;
    if (kind_is_write(k)) return STS_WRITE;
    return STS_READ;
  endfunction
endpackage

// File: rtl/bus_seq_fsm.sv
`timescale 1ns/1ps
module bus_seq_fsm
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [KIND_W-1:0] req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              ready_i,
  input  logic              hold_i,
  input  logic              halt_i,
  output seq_state_e        state_o,
  output logic [KIND_W-1:0] kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [1:0]        status_o,
  output logic              io_m_o,
  output logic              req_ready_o,
  output logic              data_end_o
);
  seq_state_e state_q, state_d;
  logic accept;

  assign req_ready_o = (state_q == ST_IDLE) && !hold_i && !halt_i;
  assign accept      = req_ready_o && req_valid_i;
  assign data_end_o  = (state_q == ST_T3) && ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (hold_i)      state_d = ST_HOLD;
        else if (halt_i) state_d = ST_HALT;
        else if (accept) state_d = ST_T1;
      end
      ST_T1: state_d = ST_T2;
      ST_T2: state_d = ST_T3;
      ST_T3: if (ready_i) state_d = (kind_o == KIND_FETCH) ? ST_T4 : ST_IDLE;
      ST_T4: state_d = ST_IDLE;
      ST_HALT: begin
        if (hold_i)       state_d = ST_HOLD;
        else if (!halt_i) state_d = ST_IDLE;
      end
      ST_HOLD: if (!hold_i) state_d = ST_HREL;
      ST_HREL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      kind_o   <= KIND_FETCH;
      addr_o   <= '0;
      wdata_o  <= '0;
      status_o <= STS_HALT;
      io_m_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        kind_o   <= req_kind_i;
        addr_o   <= req_addr_i;
        wdata_o  <= req_wdata_i;
        status_o <= kind_status(req_kind_i);
        io_m_o   <= kind_is_io(req_kind_i);
      end else if (state_d == ST_HALT && state_q != ST_HALT) begin
        status_o <= STS_HALT;
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/bus_seq_pins.sv
`timescale 1ns/1ps
module bus_seq_pins
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  seq_state_e        state_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              addr_oe_o,
  output logic              ad_oe_o,
  output logic              ctl_oe_o,
  output logic              hlda_o
);
  logic strobe_ph, is_wr, bus_own;

  assign is_wr     = kind_is_write(kind_i);
  assign strobe_ph = (state_i == ST_T2) || (state_i == ST_T3);
  assign bus_own   = !((state_i == ST_HALT) || (state_i == ST_HOLD) || (state_i == ST_HREL));

  assign ale_o     = (state_i == ST_T1);
  assign rd_no     = !(strobe_ph && !is_wr);
  assign wr_no     = !(strobe_ph && is_wr);
  assign addr_hi_o = addr_i[ADDR_W-1:DATA_W];
  assign ad_o      = (state_i == ST_T1) ? addr_i[DATA_W-1:0] : wdata_i;
  assign ad_oe_o   = (state_i == ST_T1) || (strobe_ph && is_wr);
  assign addr_oe_o = bus_own;
  assign ctl_oe_o  = bus_own;
  assign hlda_o    = (state_i == ST_HOLD);
endmodule

// File: rtl/bus_seq_capture.sv
`timescale 1ns/1ps
module bus_seq_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_end_i,
  input  logic              is_read_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= data_end_i;
      if (data_end_i && is_read_i) rdata_o <= ad_i;
    end
  end
endmodule

// File: rtl/bus_cycle_seq.sv
`timescale 1ns/1ps
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  input  logic              ready_i,
  input  logic              hold_i,
  output logic              hlda_o,
  input  logic              halt_i,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              io_m_o,
  output logic              s1_o,
  output logic              s0_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [DATA_W-1:0] ad_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic              addr_oe_o,
  output logic              ad_oe_o,
  output logic              ctl_oe_o
);
  seq_state_e        state;
  logic [KIND_W-1:0] kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        status_q;
  logic              data_end;

  bus_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni, .req_valid_i, .req_kind_i, .req_addr_i, .req_wdata_i,
    .ready_i, .hold_i, .halt_i,
    .state_o(state), .kind_o(kind_q), .addr_o(addr_q), .wdata_o(wdata_q),
    .status_o(status_q), .io_m_o(io_m_o), .req_ready_o(req_ready_o),
    .data_end_o(data_end)
  );

  bus_seq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .state_i(state), .kind_i(kind_q), .addr_i(addr_q), .wdata_i(wdata_q),
    .ale_o, .rd_no, .wr_no, .addr_hi_o, .ad_o, .addr_oe_o, .ad_oe_o,
    .ctl_oe_o, .hlda_o
  );

  bus_seq_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i, .rst_ni, .data_end_i(data_end),
    .is_read_i(!kind_is_write(kind_q)), .ad_i, .rdata_o, .done_o
  );

  assign s1_o = status_q[1];
  assign s0_o = status_q[0];
endmodule

// File: rtl/bus_cycle_seq_chk.sv
`timescale 1ns/1ps
module bus_cycle_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic done_o,
  input logic ready_i,
  input logic hold_i,
  input logic hlda_o,
  input logic ale_o,
  input logic rd_no,
  input logic wr_no,
  input logic addr_oe_o,
  input logic ad_oe_o,
  input logic ctl_oe_o
);
  p_strobe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));

  p_ale_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (rd_no && wr_no && ad_oe_o));

  p_ale_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |-> $past(req_valid_i && req_ready_o));

  p_wait_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!rd_no || !wr_no) && !ready_i) |=> (!rd_no || !wr_no));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_grant_boundary_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hlda_o) |-> $past(hold_i && rd_no && wr_no && !ale_o));

  p_grant_float_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!addr_oe_o && !ad_oe_o && !ctl_oe_o && !req_ready_o));

  p_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hlda_o && !hold_i) |=> (!hlda_o && !addr_oe_o && !ctl_oe_o));
endmodule

bind bus_cycle_seq bus_cycle_seq_chk chk_i (.*);

// File: tb/bus_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_seq_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [2:0] req_kind_i = '0;
  logic [15:0] req_addr_i = '0;
  logic [7:0] req_wdata_i = '0;
  logic req_ready_o, done_o, hlda_o, ale_o, rd_no, wr_no, io_m_o, s1_o, s0_o;
  logic [7:0] rdata_o, addr_hi_o, ad_o;
  logic [7:0] ad_i = '0;
  logic ready_i = 1'b1, hold_i = 1'b0, halt_i = 1'b0;
  logic addr_oe_o, ad_oe_o, ctl_oe_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] last_rd = '0;

  always #5 clk_i = ~clk_i;

  bus_cycle_seq dut_i (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sts(logic [2:0] k);
    if (k == 3'd0) return 2'b11;
    if (k == 3'd2 || k == 3'd4) return 2'b01;
    return 2'b10;
  endfunction
  function automatic logic exp_io(logic [2:0] k);
    return (k == 3'd3) || (k == 3'd4);
  endfunction
  function automatic logic exp_wr(logic [2:0] k);
    return (k == 3'd2) || (k == 3'd4);
  endfunction

  task automatic run_cycle(logic [2:0] k, logic [15:0] a, logic [7:0] wd,
                           int waits, logic [7:0] rv);
    @(negedge clk_i);
    check("R8 ready in idle", req_ready_o, 1);
    req_valid_i = 1; req_kind_i = k; req_addr_i = a; req_wdata_i = wd; ready_i = 1;
    @(negedge clk_i);
    req_valid_i = 0;
    check("R3 ale", ale_o, 1);
    check("R3 ad low addr", ad_o, a[7:0]);
    check("R3 high addr", addr_hi_o, a[15:8]);
    check("R3 strobes idle", {rd_no, wr_no, ad_oe_o}, 3'b111);
    check("R2 status", {s1_o, s0_o}, exp_sts(k));
    check("R2 io_m", io_m_o, exp_io(k));
    @(negedge clk_i);
    check("R4 strobes t2", {rd_no, wr_no}, exp_wr(k) ? 2'b10 : 2'b01);
    if (exp_wr(k)) check("R4 write data", {ad_oe_o, ad_o}, {1'b1, wd});
    else check("R4 read float", ad_oe_o, 0);
    ad_i = rv;
    ready_i = (waits == 0);
    @(negedge clk_i);
    check("R4 strobes t3", {rd_no, wr_no}, exp_wr(k) ? 2'b10 : 2'b01);
    for (int w = 0; w < waits; w++) begin
      @(negedge clk_i);
      check("R5 wait strobe", {rd_no, wr_no}, exp_wr(k) ? 2'b10 : 2'b01);
      if (w == waits - 1) ready_i = 1;
    end
    @(negedge clk_i);
    ad_i = 8'h00;
    if (!exp_wr(k)) last_rd = rv;
    check("R6 done", done_o, 1);
    check("R6 rdata", rdata_o, last_rd);
    check("R4 strobes off", {rd_no, wr_no}, 2'b11);
    check("R2 status held", {s1_o, s0_o}, exp_sts(k));
    check("R7 length", req_ready_o, (k == 3'd0) ? 0 : 1);
    @(negedge clk_i);
    check("R6 done one clock", done_o, 0);
    check("R7 idle after", req_ready_o, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 reset hlda", hlda_o, 0);
    check("R1 reset strobes", {ale_o, rd_no, wr_no, done_o}, 4'b0110);
    check("R1 reset enables", {addr_oe_o, req_ready_o}, 2'b11);

    // directed: each kind, zero and long wait
    run_cycle(3'd0, 16'hA55A, 8'h00, 0, 8'h3C);
    run_cycle(3'd1, 16'h1234, 8'h00, 3, 8'hC3);
    run_cycle(3'd2, 16'hFFFF, 8'h99, 2, 8'h00);
    run_cycle(3'd3, 16'h0001, 8'h00, 1, 8'h7E);
    run_cycle(3'd4, 16'h8000, 8'h5A, 0, 8'h00);

    for (int i = 0; i < 40; i++) begin
      run_cycle(3'($urandom_range(4, 0)), 16'($urandom), 8'($urandom),
                int'($urandom_range(3, 0)), 8'($urandom));
    end

    // hold in idle
    @(negedge clk_i);
    hold_i = 1;
    @(negedge clk_i);
    check("R9 grant from idle", hlda_o, 1);
    check("R10 float on grant", {addr_oe_o, ad_oe_o, ctl_oe_o}, 3'b000);
    check("R8 not ready in hold", req_ready_o, 0);
    req_valid_i = 1; req_kind_i = 3'd1;
    @(negedge clk_i);
    check("R8 request ignored", ale_o, 0);
    req_valid_i = 0;
    hold_i = 0;
    @(negedge clk_i);
    check("R11 hlda drops", hlda_o, 0);
    check("R11 still floating", {addr_oe_o, ctl_oe_o}, 2'b00);
    @(negedge clk_i);
    check("R11 bus back", {addr_oe_o, ctl_oe_o, req_ready_o}, 3'b111);
    check("R8 no late start", ale_o, 0);

    // hold raised mid-cycle
    @(negedge clk_i);
    req_valid_i = 1; req_kind_i = 3'd1; req_addr_i = 16'h4242; ready_i = 1;
    @(negedge clk_i);
    req_valid_i = 0;
    hold_i = 1;
    ad_i = 8'hE1;
    @(negedge clk_i);
    check("R9 no grant mid-cycle t2", hlda_o, 0);
    @(negedge clk_i);
    check("R9 no grant mid-cycle t3", hlda_o, 0);
    @(negedge clk_i);
    check("R9 cycle completes", {done_o, hlda_o}, 2'b10);
    check("R6 rdata mid-hold", rdata_o, 8'hE1);
    @(negedge clk_i);
    check("R9 grant after boundary", hlda_o, 1);
    hold_i = 0;
    repeat (2) @(negedge clk_i);
    check("R11 return", req_ready_o, 1);

    // halt
    halt_i = 1;
    @(negedge clk_i);
    check("R12 halt status", {s1_o, s0_o}, 2'b00);
    check("R10 halt float", {addr_oe_o, ad_oe_o, ctl_oe_o}, 3'b000);
    check("R8 not ready halted", req_ready_o, 0);
    req_valid_i = 1; req_kind_i = 3'd2;
    @(negedge clk_i);
    check("R8 halt ignores request", ale_o, 0);
    req_valid_i = 0;
    halt_i = 0;
    @(negedge clk_i);
    check("R12 leave halt", {addr_oe_o, req_ready_o, hlda_o}, 3'b110);
    run_cycle(3'd3, 16'h00F0, 8'h00, 1, 8'h81);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule